// File: doc/BRIEF.md
# Row-Clustering Bank Request Queue

This block sits in front of one DRAM bank and holds the requests waiting for it. Writes go into an age-ordered write queue and are acknowledged as soon as they are taken. Each read is first checked against the pending writes. If it names the same row and column as a pending write, it gets the data of the newest such write and completes at once. Otherwise it is stored as a pending read. Pending reads are grouped by row into bursts. Bursts are ranked by the arrival time of their first read, and the reads inside a burst keep their issue order.

A downstream bank arbiter sees two combinational views: the next read to serve and a selectable pending write. It removes entries with pop strobes. For writes, the arbiter gives the currently open row. The block returns the age index of the oldest write to that row, and the arbiter can choose to view and pop that write instead of the oldest write. Reads and writes share one pool of entries, and the write queue also has its own smaller limit.

Read selection is a two-state machine. In `BS_SCAN` the view shows the oldest pending read. Popping that read takes transition T_OPEN to `BS_BURST` if other reads of its row remain (or one arrives in the same cycle); otherwise it stays in `BS_SCAN` (T_SINGLE). In `BS_BURST` the view shows the oldest read of the active row. A pop takes T_CONTINUE (stay) while more reads of that row remain, and T_CLOSE back to `BS_SCAN` on the last one. A read that arrives for the active row during `BS_BURST` joins the burst. Pushes and pops take effect at the next rising clock edge, and the views are combinational from the stored state.

Top module: `bq_request_queue`

## Requirements
- R1: After reset `req_ready` is 1. `rd_head_valid`, `wq_head_valid`, `wq_hit_valid`, `wq_full` and `rsp_valid` are 0, and `wq_count` is 0.
- R2: An accepted write produces, in the next cycle, `rsp_valid`=1 with `rsp_wr`=1 and `rsp_data`=0. Writes are kept in arrival order, and with `wq_pick_hit`=0 the write view and `wq_pop` always present and remove the oldest one.
- R3: A read whose row and column equal those of a pending write produces, in the next cycle, `rsp_valid`=1, `rsp_wr`=0 and the data of the most recently accepted matching write. It does not enter the read queue.
- R4: A read that misses the writes and targets the row of a pending burst joins that burst. It is served after that burst's earlier reads and before any read of a burst whose first read arrived later.
- R5: A read for a row with no pending burst starts a new burst. Bursts are served in the order in which their first reads arrived.
- R6: Once a read of a burst has been popped, the remaining reads of that row are served before any other read. This includes reads for that row that arrive while the burst still has entries.
- R7: Reads within a burst are served in issue order.
- R8: `wq_full` is 1 exactly when `wq_count` equals the write capacity. While it is 1, `req_ready` is 0 for a write (`req_wr`=1), a write offered then is not taken, and reads are still accepted if the pool has room.
- R9: When pending reads plus pending writes equal the pool capacity, `req_ready` is 0 for every request.
- R10: `wq_hit_valid`/`wq_hit_idx` give the lowest age index (0 = oldest) of a pending write whose row equals `wq_open_row`. With `wq_pick_hit`=1 the write view shows that write, `wq_pop` removes it, and the other writes keep their order.
- R11: `rd_pop` while `rd_head_valid` is 0, and `wq_pop` while `wq_head_valid` is 0, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row part of the address |
| req_col | input | COL_W | Column part of the address |
| req_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response this cycle |
| rsp_wr | output | 1 | 1 = write acknowledge, 0 = forwarded read |
| rsp_data | output | DATA_W | Forwarded read data, 0 for writes |
| rd_head_valid | output | 1 | A pending read is available |
| rd_head_row | output | ROW_W | Row of the read to serve next |
| rd_head_col | output | COL_W | Column of the read to serve next |
| rd_pop | input | 1 | Remove the read in view |
| wq_open_row | input | ROW_W | Row currently open in the bank |
| wq_pick_hit | input | 1 | 1 = view oldest write to the open row, 0 = oldest write |
| wq_hit_valid | output | 1 | Some pending write targets the open row |
| wq_hit_idx | output | $clog2(WQ_DEPTH) | Age index of the oldest such write |
| wq_head_valid | output | 1 | Selected write view is valid |
| wq_head_row | output | ROW_W | Row of the selected write |
| wq_head_col | output | COL_W | Column of the selected write |
| wq_head_data | output | DATA_W | Data of the selected write |
| wq_pop | input | 1 | Remove the selected write |
| wq_count | output | $clog2(WQ_DEPTH+1) | Pending writes |
| wq_full | output | 1 | Write queue at capacity |

## Verification
A wrong burst register or state shows in the first cycle after a pop: `rd_head_row` points at another row while reads of the active row are still pending, or it stays on a row that has no reads left. Faulty compaction in either queue appears as a head entry out of age order at the next view. It can also appear as a wrong `wq_hit_idx` as soon as the open row is driven. A bad forwarding search shows one cycle after the read is accepted: the response is missing, carries the older write's data, or the read also turns up later in the read view. A wrong count appears immediately in `req_ready` and `wq_full` at the capacity boundaries.

// File: rtl/bq_pkg.sv
package bq_pkg;
    typedef enum logic {
        BS_SCAN  = 1'b0,
        BS_BURST = 1'b1
    } burst_state_e;
endpackage

// File: rtl/bq_write_queue.sv
module bq_write_queue #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [COL_W-1:0]  push_col,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              pick_hit,
    input  logic [ROW_W-1:0]  open_row,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic [COL_W-1:0]  lk_col,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              hit_valid,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              view_valid,
    output logic [ROW_W-1:0]  view_row,
    output logic [COL_W-1:0]  view_col,
    output logic [DATA_W-1:0] view_data
);
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [COL_W-1:0]  col_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [IDX_W-1:0]  sel_idx;
    logic [CNT_W-1:0]  wr_ptr;
    logic              pop_e;

    always_comb begin
        hit_valid = 1'b0;
        hit_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(count) && row_q[i] == open_row) begin
                hit_valid = 1'b1;
                hit_idx   = IDX_W'(i);
            end
        end
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count) && row_q[i] == lk_row && col_q[i] == lk_col) begin
                lk_hit  = 1'b1;
                lk_data = data_q[i];
            end
        end
        sel_idx    = pick_hit ? hit_idx : '0;
        view_valid = pick_hit ? hit_valid : (count != '0);
        view_row   = row_q[sel_idx];
        view_col   = col_q[sel_idx];
        view_data  = data_q[sel_idx];
        pop_e      = pop && view_valid;
        wr_ptr     = count - CNT_W'(pop_e);
        full       = (count == CNT_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop_e && i >= int'(sel_idx)) begin
                row_q[i]  <= row_q[i+1];
                col_q[i]  <= col_q[i+1];
                data_q[i] <= data_q[i+1];
            end
        end
        if (push) begin
            row_q[IDX_W'(wr_ptr)]  <= push_row;
            col_q[IDX_W'(wr_ptr)]  <= push_col;
            data_q[IDX_W'(wr_ptr)] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(push) - CNT_W'(pop_e);
    end

    // R8: no write is stored into a full queue
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R11: a pop with nothing in view leaves the occupancy alone
    p_idle_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !view_valid && !push) |=> count == $past(count));
    // R10: the reported hit really targets the open row
    p_hit_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && pick_hit) |-> (view_valid && view_row == open_row));
endmodule

// File: rtl/bq_read_queue.sv
module bq_read_queue
    import bq_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic [COL_W-1:0] push_col,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic             view_valid,
    output logic [ROW_W-1:0] view_row,
    output logic [COL_W-1:0] view_col
);
    logic [ROW_W-1:0] row_q [DEPTH];
    logic [COL_W-1:0] col_q [DEPTH];
    burst_state_e     st, st_nx;
    logic [ROW_W-1:0] act_row, act_nx;
    logic             b_hit, stay, pop_e;
    logic [IDX_W-1:0] b_idx, head_idx;
    logic [CNT_W-1:0] wr_ptr;
    int               n_same;

    always_comb begin
        b_hit = 1'b0;
        b_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(count) && row_q[i] == act_row) begin
                b_hit = 1'b1;
                b_idx = IDX_W'(i);
            end
        end
        head_idx   = (st == BS_BURST && b_hit) ? b_idx : '0;
        view_valid = (count != '0);
        view_row   = row_q[head_idx];
        view_col   = col_q[head_idx];
        pop_e      = pop && view_valid;
        wr_ptr     = count - CNT_W'(pop_e);
        n_same     = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count) && row_q[i] == view_row) n_same++;
        end
        stay   = (n_same > 1) || (push && push_row == view_row);
        st_nx  = st;
        act_nx = act_row;
        if (pop_e) begin
            unique case (st)
                BS_SCAN: if (stay) begin
                    st_nx  = BS_BURST;
                    act_nx = view_row;
                end
                BS_BURST: if (!stay) st_nx = BS_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BS_SCAN;
            act_row <= '0;
            count   <= '0;
        end else begin
            st      <= st_nx;
            act_row <= act_nx;
            count   <= count + CNT_W'(push) - CNT_W'(pop_e);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop_e && i >= int'(head_idx)) begin
                row_q[i] <= row_q[i+1];
                col_q[i] <= col_q[i+1];
            end
        end
        if (push) begin
            row_q[IDX_W'(wr_ptr)] <= push_row;
            col_q[IDX_W'(wr_ptr)] <= push_col;
        end
    end

    // R6: while a burst is open its row stays in view
    p_burst_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BS_BURST) |-> (view_valid && view_row == act_row));
    // R9: the pool never receives a read beyond its capacity
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    // R11: popping an empty read queue changes nothing
    p_idle_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !view_valid && !push) |=> (count == $past(count) && st == $past(st)));
endmodule

// File: rtl/bq_request_queue.sv
module bq_request_queue #(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 6,
    parameter int DATA_W     = 16,
    parameter int POOL_DEPTH = 256,
    parameter int WQ_DEPTH   = 64,
    localparam int WIDX_W    = $clog2(WQ_DEPTH),
    localparam int WCNT_W    = $clog2(WQ_DEPTH + 1),
    localparam int PCNT_W    = $clog2(POOL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_wr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rd_head_valid,
    output logic [ROW_W-1:0]  rd_head_row,
    output logic [COL_W-1:0]  rd_head_col,
    input  logic              rd_pop,
    input  logic [ROW_W-1:0]  wq_open_row,
    input  logic              wq_pick_hit,
    output logic              wq_hit_valid,
    output logic [WIDX_W-1:0] wq_hit_idx,
    output logic              wq_head_valid,
    output logic [ROW_W-1:0]  wq_head_row,
    output logic [COL_W-1:0]  wq_head_col,
    output logic [DATA_W-1:0] wq_head_data,
    input  logic              wq_pop,
    output logic [WCNT_W-1:0] wq_count,
    output logic              wq_full
);
    logic              accept, lk_hit, rd_push, wr_push;
    logic [DATA_W-1:0] lk_data;
    logic [PCNT_W-1:0] rd_count, pool_used;

    assign pool_used = rd_count + PCNT_W'(wq_count);
    assign req_ready = (pool_used < PCNT_W'(POOL_DEPTH)) && !(req_wr && wq_full);
    assign accept    = req_valid && req_ready;
    assign wr_push   = accept && req_wr;
    assign rd_push   = accept && !req_wr && !lk_hit;

    bq_write_queue #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .DEPTH(WQ_DEPTH)
    ) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_push), .push_row(req_row), .push_col(req_col), .push_data(req_data),
        .pop(wq_pop), .pick_hit(wq_pick_hit), .open_row(wq_open_row),
        .lk_row(req_row), .lk_col(req_col), .lk_hit(lk_hit), .lk_data(lk_data),
        .count(wq_count), .full(wq_full),
        .hit_valid(wq_hit_valid), .hit_idx(wq_hit_idx),
        .view_valid(wq_head_valid), .view_row(wq_head_row),
        .view_col(wq_head_col), .view_data(wq_head_data)
    );

    bq_read_queue #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(POOL_DEPTH)
    ) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(rd_push), .push_row(req_row), .push_col(req_col),
        .pop(rd_pop), .count(rd_count),
        .view_valid(rd_head_valid), .view_row(rd_head_row), .view_col(rd_head_col)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept && (req_wr || lk_hit);
            rsp_wr    <= req_wr;
            rsp_data  <= req_wr ? '0 : lk_data;
        end
    end

    // R2: every accepted write is acknowledged one cycle later
    p_wr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push |=> (rsp_valid && rsp_wr));
    // R3: a forwarded read answers next cycle and is not queued
    p_fwd_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_wr && lk_hit) |=> (rsp_valid && !rsp_wr && rd_count == $past(rd_count) - PCNT_W'($past(rd_pop && rd_head_valid))));
    // R9: combined occupancy stays within the pool
    p_pool_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_used <= PCNT_W'(POOL_DEPTH));
    // R8: a full write queue refuses writes
    p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wq_full && req_wr) |-> !req_ready);
endmodule

// File: tb/tb_bq_request_queue.sv
module tb_bq_request_queue;
    localparam int RW = 4, CW = 4, DW = 8, PD = 8, WD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, rsp_valid, rsp_wr;
    logic [DW-1:0] rsp_data;
    logic rd_head_valid;
    logic [RW-1:0] rd_head_row;
    logic [CW-1:0] rd_head_col;
    logic rd_pop = 1'b0;
    logic [RW-1:0] wq_open_row = '0;
    logic wq_pick_hit = 1'b0;
    logic wq_hit_valid;
    logic [$clog2(WD)-1:0] wq_hit_idx;
    logic wq_head_valid;
    logic [RW-1:0] wq_head_row;
    logic [CW-1:0] wq_head_col;
    logic [DW-1:0] wq_head_data;
    logic wq_pop = 1'b0;
    logic [$clog2(WD+1)-1:0] wq_count;
    logic wq_full;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    bit    exp_wr[$];
    int    exp_data[$];
    string exp_tag[$];

    always #5 clk = ~clk;

    bq_request_queue #(
        .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .POOL_DEPTH(PD), .WQ_DEPTH(WD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_row(req_row), .req_col(req_col), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_wr(rsp_wr), .rsp_data(rsp_data),
        .rd_head_valid(rd_head_valid), .rd_head_row(rd_head_row), .rd_head_col(rd_head_col),
        .rd_pop(rd_pop), .wq_open_row(wq_open_row), .wq_pick_hit(wq_pick_hit),
        .wq_hit_valid(wq_hit_valid), .wq_hit_idx(wq_hit_idx),
        .wq_head_valid(wq_head_valid), .wq_head_row(wq_head_row),
        .wq_head_col(wq_head_col), .wq_head_data(wq_head_data),
        .wq_pop(wq_pop), .wq_count(wq_count), .wq_full(wq_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares each response with the oldest expected one
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_wr.size() == 0) begin
                chk("R2/R3 unexpected response", 1, 0);
            end else begin
                automatic string t = exp_tag.pop_front();
                automatic bit w = exp_wr.pop_front();
                automatic int d = exp_data.pop_front();
                chk({t, " rsp_wr"}, int'(rsp_wr), int'(w));
                chk({t, " rsp_data"}, int'(rsp_data), d);
            end
        end
    end

    task automatic send(input bit wr, input int row, input int col, input int data,
                        input bit exp_acc, input bit exp_rsp, input int exp_d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr;
        req_row = RW'(row); req_col = CW'(col); req_data = DW'(data);
        #1;
        chk({tag, " ready"}, int'(req_ready), int'(exp_acc));
        if (exp_acc && exp_rsp) begin
            exp_wr.push_back(wr); exp_data.push_back(exp_d); exp_tag.push_back(tag);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic pop_rd(input int row, input int col, input string tag);
        @(negedge clk);
        chk({tag, " rd valid"}, int'(rd_head_valid), 1);
        chk({tag, " rd row"}, int'(rd_head_row), row);
        chk({tag, " rd col"}, int'(rd_head_col), col);
        rd_pop = 1'b1;
        @(posedge clk); #1;
        rd_pop = 1'b0;
    endtask

    task automatic pop_wr(input bit pick, input int open, input int row, input int col,
                          input int data, input string tag);
        @(negedge clk);
        wq_pick_hit = pick; wq_open_row = RW'(open);
        #1;
        chk({tag, " wr valid"}, int'(wq_head_valid), 1);
        chk({tag, " wr row"}, int'(wq_head_row), row);
        chk({tag, " wr col"}, int'(wq_head_col), col);
        chk({tag, " wr data"}, int'(wq_head_data), data);
        wq_pop = 1'b1;
        @(posedge clk); #1;
        wq_pop = 1'b0; wq_pick_hit = 1'b0;
    endtask

    task automatic peek_hit(input int open, input int exp_v, input int exp_i, input string tag);
        @(negedge clk);
        wq_open_row = RW'(open);
        #1;
        chk({tag, " hit valid"}, int'(wq_hit_valid), exp_v);
        if (exp_v != 0) chk({tag, " hit idx"}, int'(wq_hit_idx), exp_i);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 rd valid", int'(rd_head_valid), 0);
        chk("R1 wr valid", int'(wq_head_valid), 0);
        chk("R1 hit valid", int'(wq_hit_valid), 0);
        chk("R1 full", int'(wq_full), 0);
        chk("R1 count", int'(wq_count), 0);
        chk("R1 rsp", int'(rsp_valid), 0);

        // R2: writes acknowledged and kept in order
        send(1, 3, 1, 8'hA1, 1, 1, 0, "R2 w0");
        send(1, 5, 2, 8'hB2, 1, 1, 0, "R2 w1");
        send(1, 3, 1, 8'hC3, 1, 1, 0, "R2 w2");
        @(negedge clk);
        chk("R2 count", int'(wq_count), 3);
        chk("R2 oldest row", int'(wq_head_row), 3);
        chk("R2 oldest data", int'(wq_head_data), 8'hA1);

        // R3: read forwarded from newest matching write, not queued
        send(0, 3, 1, 0, 1, 1, 8'hC3, "R3 fwd");
        @(negedge clk);
        chk("R3 not queued", int'(rd_head_valid), 0);

        // R10: oldest write to the open row
        peek_hit(5, 1, 1, "R10 row5");
        peek_hit(3, 1, 0, "R10 row3");
        peek_hit(7, 0, 0, "R10 row7");

        // R8: full write queue refuses writes, keeps reads
        send(1, 7, 0, 8'hD4, 1, 1, 0, "R2 w3");
        @(negedge clk);
        chk("R8 full", int'(wq_full), 1);
        send(1, 9, 9, 8'hEE, 0, 0, 0, "R8 write refused");
        @(negedge clk);
        chk("R8 count held", int'(wq_count), 4);

        // R5/R4: bursts by row, ordered by first arrival
        send(0, 2, 1, 0, 1, 0, 0, "R8 read taken a");
        send(0, 6, 1, 0, 1, 0, 0, "R5 read b");
        send(0, 2, 2, 0, 1, 0, 0, "R4 read c");
        send(0, 6, 3, 0, 1, 0, 0, "R5 read d");
        // R9: pool full
        send(0, 1, 1, 0, 0, 0, 0, "R9 pool full");

        pop_rd(2, 1, "R5 first burst head");
        @(negedge clk);
        chk("R4 joined read next", int'(rd_head_col), 2);
        chk("R4 joined read row", int'(rd_head_row), 2);

        // R10: pick the row-7 write out of the middle order
        peek_hit(7, 1, 3, "R10 row7 idx");
        pop_wr(1, 7, 7, 0, 8'hD4, "R10 pick hit");

        // R6: late read joins the open burst
        send(0, 2, 5, 0, 1, 0, 0, "R6 late join");
        pop_rd(2, 2, "R7 burst order");
        pop_rd(2, 5, "R6 late joiner");
        pop_rd(6, 1, "R5 second burst");
        pop_rd(6, 3, "R7 second burst tail");
        @(negedge clk);
        chk("R6 read queue empty", int'(rd_head_valid), 0);

        // R11: pops on empty views are ignored
        @(negedge clk);
        rd_pop = 1'b1;
        @(posedge clk); #1 rd_pop = 1'b0;
        send(0, 9, 4, 0, 1, 0, 0, "R11 read after idle pop");
        @(negedge clk);
        chk("R11 read kept", int'(rd_head_valid), 1);
        chk("R11 read row", int'(rd_head_row), 9);
        @(negedge clk);
        wq_pick_hit = 1'b1; wq_open_row = 4'd12; wq_pop = 1'b1;
        @(posedge clk); #1 wq_pop = 1'b0; wq_pick_hit = 1'b0;
        @(negedge clk);
        chk("R11 writes kept", int'(wq_count), 3);

        // R2/R10: remaining writes drain oldest first
        pop_wr(0, 0, 3, 1, 8'hA1, "R2 drain w0");
        pop_wr(0, 0, 5, 2, 8'hB2, "R2 drain w1");
        pop_wr(0, 0, 3, 1, 8'hC3, "R2 drain w2");
        pop_rd(9, 4, "R11 final read");
        @(negedge clk);
        chk("R2 writes empty", int'(wq_count), 0);
        chk("R8 not full", int'(wq_full), 0);
        chk("R3 scoreboard drained", exp_wr.size(), 0);
        finish_run();
    end
endmodule